// File: doc/BRIEF.md
# Interrupt Mask and Entry Sequencer

This block decides when a small 8-bit CPU core takes an interrupt, and it performs the register save that goes with it. It holds the condition-code byte of the core, including two mask bits. The X mask gates a single nonmaskable request line. The I mask gates a group of ordinary maskable request lines. While the block is idle it checks the request lines every cycle against these masks. When it accepts a request, it takes a snapshot of the program counter, the two index registers, the two accumulators and the condition-code byte. It then writes these nine bytes to a stack that grows downward, one byte per clock.

The X mask can only be cleared by software. Hardware sets it again at reset and on entry to the nonmaskable interrupt. Once initialisation has cleared it, the nonmaskable line cannot be shut off by software. The core reads the mask bits, the stack pointer and a code for the accepted source from the ports. It loads the stack pointer and the condition-code byte through the block's write inputs.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, X (ccr bit 6) and I (ccr bit 4) read 1, `busy` and `mem_we` are 0 and `sp_out` equals the `SP_RESET` parameter. Requests raised in that state are not accepted.
- R2: A condition-code write may change X from 1 to 0. A write that tries to change X from 0 to 1 leaves X at 0. Only reset and nonmaskable entry set X.
- R3: The I bit and the other six bits of a condition-code write are stored exactly as written. The new value is visible on the next cycle.
- R4: The nonmaskable request is accepted whenever X is 0, whatever the value of I. It is never accepted while X is 1.
- R5: When the nonmaskable request and a maskable request are both acceptable, the nonmaskable one is taken. `src_code` then reads 7.
- R6: A maskable request is accepted only when I is 0. Among the maskable lines, index 0 has the highest priority. `src_code` reports the index of the line taken.
- R7: In the nine cycles after acceptance, `mem_we` is 1 and the block writes one byte per cycle. With S the entry stack pointer, the writes are: PC low to S, PC high to S-1, IY low to S-2, IY high to S-3, IX low to S-4, IX high to S-5, ACCA to S-6, ACCB to S-7, and the condition-code byte to S-8.
- R8: `done` is high for exactly the one cycle after the last write. In that cycle `sp_out` equals S-9.
- R9: The condition-code byte written to the stack holds the values it had before entry, including the old X and I.
- R10: From the `done` cycle onward, I is 1 after any entry. X is also 1 after a nonmaskable entry, and X is unchanged after a maskable entry.
- R11: During a push sequence, the request lines, condition-code writes and stack-pointer loads have no effect. A request still held when the sequence ends is evaluated in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xirq_req | input | 1 | Nonmaskable request, level |
| irq_req | input | NUM_SRC | Maskable requests, index 0 highest |
| pc_in | input | 16 | Program counter to save |
| ix_in | input | 16 | Index register X to save |
| iy_in | input | 16 | Index register Y to save |
| acca_in | input | 8 | Accumulator A to save |
| accb_in | input | 8 | Accumulator B to save |
| ccr_wr_en | input | 1 | Condition-code write strobe |
| ccr_wr_data | input | 8 | Condition-code write value |
| sp_load | input | 1 | Stack-pointer load strobe |
| sp_load_val | input | 16 | Stack-pointer load value |
| mem_we | output | 1 | Stack byte write enable |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack byte data |
| sp_out | output | 16 | Current stack pointer |
| x_mask | output | 1 | X mask bit |
| i_mask | output | 1 | I mask bit |
| busy | output | 1 | Push sequence running |
| done | output | 1 | One-cycle pulse after the final write |
| src_code | output | 3 | Accepted source: maskable index, or 7 for nonmaskable |

## Verification
The assertions assume that `NUM_SRC` is at most 7, so that no maskable index collides with code 7. They also assume that the stack pointer is not loaded with a value below 9 before an entry, which would make the decrement wrap. The bench uses four maskable lines and loads stack values well above the bottom of memory. It drives requests, strobes and register values at the falling edge only, so every input is stable at the accepting edge. The sweep covers every combination of the four request lines, the nonmaskable line, X and I.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 3;
    localparam int X_BIT     = 6;
    localparam int I_BIT     = 4;
    localparam int PUSH_LEN  = 9;
    localparam int STEP_W    = $clog2(PUSH_LEN);
    localparam logic [CODE_W-1:0] XIRQ_CODE = CODE_W'(7);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] iy;
        logic [ADDR_W-1:0] ix;
        logic [BYTE_W-1:0] acca;
        logic [BYTE_W-1:0] accb;
        logic [BYTE_W-1:0] ccr;
    } regsnap_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_entry_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               valid,
    output logic [CODE_W-1:0]  idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (req[k]) begin
                valid = 1'b1;
                idx   = CODE_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_push_mux.sv
module irq_push_mux
    import irq_entry_pkg::*;
(
    input  regsnap_t            snap,
    input  logic [STEP_W-1:0]   step,
    output logic [BYTE_W-1:0]   byte_out
);
    always_comb begin
        unique case (step)
            STEP_W'(0): byte_out = snap.pc[7:0];
            STEP_W'(1): byte_out = snap.pc[15:8];
            STEP_W'(2): byte_out = snap.iy[7:0];
            STEP_W'(3): byte_out = snap.iy[15:8];
            STEP_W'(4): byte_out = snap.ix[7:0];
            STEP_W'(5): byte_out = snap.ix[15:8];
            STEP_W'(6): byte_out = snap.acca;
            STEP_W'(7): byte_out = snap.accb;
            default:    byte_out = snap.ccr;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                NUM_SRC  = 4,
    parameter logic [ADDR_W-1:0] SP_RESET = 16'h01FF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xirq_req,
    input  logic [NUM_SRC-1:0]  irq_req,
    input  logic [ADDR_W-1:0]   pc_in,
    input  logic [ADDR_W-1:0]   ix_in,
    input  logic [ADDR_W-1:0]   iy_in,
    input  logic [BYTE_W-1:0]   acca_in,
    input  logic [BYTE_W-1:0]   accb_in,
    input  logic                ccr_wr_en,
    input  logic [BYTE_W-1:0]   ccr_wr_data,
    input  logic                sp_load,
    input  logic [ADDR_W-1:0]   sp_load_val,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic [ADDR_W-1:0]   sp_out,
    output logic                x_mask,
    output logic                i_mask,
    output logic                busy,
    output logic                done,
    output logic [CODE_W-1:0]   src_code
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PUSH_LEN - 1);

    typedef struct packed {
        logic                busy;
        logic [STEP_W-1:0]   step;
        logic [ADDR_W-1:0]   sp;
        logic [BYTE_W-1:0]   ccr;
        logic                done;
        logic [CODE_W-1:0]   src;
        regsnap_t            snap;
    } state_t;

    state_t s_q, s_d;

    logic              m_valid;
    logic [CODE_W-1:0] m_idx;
    logic              take_x, take_i, accept;
    logic [BYTE_W-1:0] ccr_wr_masked;

    irq_prio_enc #(.NUM_SRC(NUM_SRC)) prio_i (
        .req   (irq_req),
        .valid (m_valid),
        .idx   (m_idx)
    );

    irq_push_mux mux_i (
        .snap     (s_q.snap),
        .step     (s_q.step),
        .byte_out (mem_wdata)
    );

    assign take_x = xirq_req & ~s_q.ccr[X_BIT];
    assign take_i = m_valid  & ~s_q.ccr[I_BIT];
    assign accept = ~s_q.busy & (take_x | take_i);

    always_comb begin
        ccr_wr_masked        = ccr_wr_data;
        ccr_wr_masked[X_BIT] = ccr_wr_data[X_BIT] & s_q.ccr[X_BIT];
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.sp = s_q.sp - ADDR_W'(1);
            if (s_q.step == LAST_STEP) begin
                s_d.busy       = 1'b0;
                s_d.done       = 1'b1;
                s_d.ccr[I_BIT] = 1'b1;
                if (s_q.src == XIRQ_CODE) begin
                    s_d.ccr[X_BIT] = 1'b1;
                end
            end else begin
                s_d.step = s_q.step + STEP_W'(1);
            end
        end else if (accept) begin
            s_d.busy      = 1'b1;
            s_d.step      = '0;
            s_d.src       = take_x ? XIRQ_CODE : m_idx;
            s_d.snap.pc   = pc_in;
            s_d.snap.iy   = iy_in;
            s_d.snap.ix   = ix_in;
            s_d.snap.acca = acca_in;
            s_d.snap.accb = accb_in;
            s_d.snap.ccr  = s_q.ccr;
        end else begin
            if (ccr_wr_en) s_d.ccr = ccr_wr_masked;
            if (sp_load)   s_d.sp  = sp_load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.sp         <= SP_RESET;
            s_q.ccr[X_BIT] <= 1'b1;
            s_q.ccr[I_BIT] <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we   = s_q.busy;
    assign mem_addr = s_q.sp;
    assign sp_out   = s_q.sp;
    assign x_mask   = s_q.ccr[X_BIT];
    assign i_mask   = s_q.ccr[I_BIT];
    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign src_code = s_q.src;

    // R2
    x_only_hw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_mask) |-> (done && src_code == XIRQ_CODE));

    // R7
    sp_walks_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mem_addr == $past(mem_addr) - ADDR_W'(1)));

    // R8
    done_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    i_set_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> i_mask);

    // R11
    src_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(src_code));
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 4;
    localparam logic [15:0] SPR = 16'h01FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xirq_req = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic [15:0] pc_in = '0, ix_in = '0, iy_in = '0;
    logic [7:0] acca_in = '0, accb_in = '0;
    logic ccr_wr_en = 1'b0;
    logic [7:0] ccr_wr_data = '0;
    logic sp_load = 1'b0;
    logic [15:0] sp_load_val = '0;
    logic mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [15:0] sp_out;
    logic x_mask, i_mask, busy, done;
    logic [2:0] src_code;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq #(.NUM_SRC(NSRC), .SP_RESET(SPR)) dut_i (
        .clk, .rst_n, .xirq_req, .irq_req, .pc_in, .ix_in, .iy_in,
        .acca_in, .accb_in, .ccr_wr_en, .ccr_wr_data, .sp_load, .sp_load_val,
        .mem_we, .mem_addr, .mem_wdata, .sp_out, .x_mask, .i_mask,
        .busy, .done, .src_code
    );

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ccr(input logic [7:0] v);
        ccr_wr_en = 1'b1; ccr_wr_data = v;
        tick();
        ccr_wr_en = 1'b0;
    endtask

    task automatic ld_sp(input logic [15:0] v);
        sp_load = 1'b1; sp_load_val = v;
        tick();
        sp_load = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input int k, input logic [7:0] cv);
        case (k)
            0: return pc_in[7:0];
            1: return pc_in[15:8];
            2: return iy_in[7:0];
            3: return iy_in[15:8];
            4: return ix_in[7:0];
            5: return ix_in[15:8];
            6: return acca_in;
            7: return accb_in;
            default: return cv;
        endcase
    endfunction

    // checks a full push started at the previous edge; bench sits on step 0
    task automatic check_push(input logic [15:0] s, input logic [7:0] cv,
                              input logic [2:0] code, input logic x_after);
        for (int k = 0; k < 9; k++) begin
            chk(mem_we == 1'b1, "R7 we", mem_we, 1);
            chk(mem_addr == s - 16'(k), "R7 addr", mem_addr, s - 16'(k));
            if (k == 8)
                chk(mem_wdata == cv, "R9 pushed ccr", mem_wdata, cv);
            else
                chk(mem_wdata == exp_byte(k, cv), "R7 data", mem_wdata, exp_byte(k, cv));
            chk(src_code == code, "R5 R6 code", src_code, code);
            tick();
        end
        chk(done == 1'b1, "R8 done", done, 1);
        chk(sp_out == s - 16'd9, "R8 sp", sp_out, s - 16'd9);
        chk(i_mask == 1'b1, "R10 i", i_mask, 1);
        chk(x_mask == x_after, "R10 x", x_mask, x_after);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        xirq_req = 1'b1; irq_req = '1;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(x_mask == 1 && i_mask == 1, "R1 masks", {x_mask, i_mask}, 3);
        chk(busy == 0 && mem_we == 0, "R1 idle", {busy, mem_we}, 0);
        rst_n = 1'b1;
        tick();
        // R1 after reset: requests raised but masked
        chk(mem_we == 0, "R1 no accept", mem_we, 0);
        chk(sp_out == SPR, "R1 sp", sp_out, SPR);
        xirq_req = 1'b0; irq_req = '0;

        // sweep: x phase 1 then 0, i, xirq, all request patterns
        for (int xt = 1; xt >= 0; xt--) begin
            for (int it = 0; it < 2; it++) begin
                for (int xr = 0; xr < 2; xr++) begin
                    for (int rq = 0; rq < 16; rq++) begin
                        int c;
                        logic [7:0] cv;
                        logic [15:0] s;
                        logic acc;
                        logic [2:0] code;
                        c = xt * 64 + it * 32 + xr * 16 + rq;
                        pc_in   = 16'h8000 + 16'(c * 257);
                        ix_in   = 16'h1000 + 16'(c * 3);
                        iy_in   = 16'h2000 + 16'(c * 7);
                        acca_in = 8'(c + 5);
                        accb_in = 8'(c * 11);
                        cv = 8'(c * 37);
                        cv[6] = 1'(xt);
                        cv[4] = 1'(it);
                        s = 16'h0400 + 16'(c * 16);
                        wr_ccr(cv);
                        // R2 R3: stored as written (X only lowered in this order)
                        chk(x_mask == 1'(xt), "R2 x write", x_mask, xt);
                        chk(i_mask == 1'(it), "R3 i write", i_mask, it);
                        ld_sp(s);
                        acc = 1'b0; code = 3'd0;
                        if (xr == 1 && xt == 0) begin
                            acc = 1'b1; code = 3'd7;          // R4 R5
                        end else if (rq != 0 && it == 0) begin
                            acc = 1'b1;                       // R6
                            for (int b = 3; b >= 0; b--) if (rq[b]) code = 3'(b);
                        end
                        xirq_req = 1'(xr); irq_req = 4'(rq);
                        tick();
                        xirq_req = 1'b0; irq_req = '0;
                        if (acc) begin
                            check_push(s, cv, code, (code == 3'd7) ? 1'b1 : 1'(xt));
                            tick();
                            chk(done == 0, "R8 pulse", done, 0);
                        end else begin
                            chk(mem_we == 0 && busy == 0, "R4 R6 masked", mem_we, 0);
                        end
                    end
                end
            end
        end

        // R2: X one-way
        wr_ccr(8'h00);
        chk(x_mask == 0, "R2 clear", x_mask, 0);
        wr_ccr(8'hFF);
        chk(x_mask == 0, "R2 no set", x_mask, 0);
        // R3: other bits as written
        chk(i_mask == 1, "R3 i set", i_mask, 1);
        wr_ccr(8'h2B);
        chk(i_mask == 0, "R3 i clear", i_mask, 0);

        // R11: stimulus during push ignored; held xirq taken after
        begin
            logic [15:0] s;
            s = 16'h0800;
            ld_sp(s);
            irq_req = 4'b0100;
            tick();
            irq_req = '0;
            tick(); tick();
            ccr_wr_en = 1'b1; ccr_wr_data = 8'hEF;
            sp_load = 1'b1; sp_load_val = 16'h0050;
            xirq_req = 1'b1; irq_req = 4'b0001;
            tick();
            ccr_wr_en = 1'b0; sp_load = 1'b0; irq_req = '0;
            repeat (6) tick();
            chk(done == 1, "R11 done", done, 1);
            chk(sp_out == s - 16'd9, "R11 sp kept", sp_out, s - 16'd9);
            chk(x_mask == 0, "R11 ccr write ignored", x_mask, 0);
            chk(src_code == 3'd2, "R11 code kept", src_code, 2);
            tick();
            chk(mem_we == 1 && src_code == 3'd7, "R11 pending xirq", src_code, 7);
            chk(mem_addr == s - 16'd9, "R11 next push addr", mem_addr, s - 16'd9);
            xirq_req = 1'b0;
            repeat (9) tick();
            chk(done == 1 && x_mask == 1, "R10 xirq sets x", x_mask, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule